// File: doc/BRIEF.md
# Infrared Edge-Interval Capture Receiver

This block is the receive front end for an infrared remote control. It takes the already demodulated IR line, passes it through a synchronizer, and measures the spacing between edges in ticks of a programmable prescaler. When an edge of the kind selected by software arrives, the block copies the measured interval into a read-only field and raises a one-cycle interrupt. Software reads the interval and the current line level, and it decodes the remote protocol itself.

Configuration and readback go through a small port that writes 32-bit words and reads them back combinationally. The decode-mode fields are held as storage only: the receiver always behaves as a raw edge timer. Five timing words are plain read/write storage. The measuring core is a three-state machine:
- **OFF**: the receiver is disabled or held in soft reset.
- **ARMED**: the receiver is enabled and waits for its first qualifying edge. No time is counted.
- **MEASURE**: ticks are counted between qualifying edges.

Transitions:
- *arm*: OFF goes to ARMED when the enable bit is set and soft reset is clear.
- *first edge*: ARMED goes to MEASURE on a qualifying edge.
- *drop*: any state goes to OFF when enable clears or soft reset is set.

Top module: `ir_edge_capture`

## Requirements
- R1: After reset, the rate word (byte address 0x10) reads 19, the control word (0x1C), the mode word (0x20) and the status word (0x18) read 0, and `irq` is low.
- R2: One tick lasts R+1 clock cycles, where R is rate bits [11:0]. The prescaler restarts on every qualifying edge. The interval latched at a qualifying edge is floor(D/(R+1)), where D is the number of clock cycles since the previous qualifying edge.
- R3: The interval appears in control bits [28:16]. Writes to those bits are ignored. The value saturates at 8191 and does not wrap.
- R4: The first qualifying edge after arming latches 8191 and raises `irq`.
- R5: Control bits [3:2] select which edges qualify: 1 selects both edges, 2 selects falling edges only, 3 selects rising edges only, and 0 selects none (decoder setting, with no raw interrupts). An edge that does not qualify latches nothing and does not restart the count.
- R6: Each qualifying edge raises `irq` for exactly one cycle. If the input changes before clock edge k+1, `irq` is high in the cycle after clock edge k+3, and the new interval is readable in that same cycle.
- R7: While control bit 15 (enable) is clear, no interrupt fires and the latched interval holds its value.
- R8: While control bit 0 (soft reset) is set, the interval, the tick counter and `irq` are held at zero. Clearing the bit with enable set arms the receiver again.
- R9: Status bit 8 reads the input level after a two-flop synchronizer. All other status bits read zero.
- R10: The writable fields read back their last written value, and unimplemented bits read zero. The writable fields are rate [11:0]; control bits 0, [3:2], [8:7] and 15; and mode [3:0].
- R11: Byte addresses 0x00, 0x04, 0x08, 0x0C and 0x14 are full 32-bit storage. Unmapped addresses read zero.
- R12: The core follows the OFF / ARMED / MEASURE states and transitions listed above. Disabling the receiver and enabling it again always re-arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 6 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| ir_in | input | 1 | Demodulated IR line (asynchronous) |
| irq | output | 1 | One-cycle pulse per qualifying edge |

## Verification
Assertions check the following on every cycle:
- `irq` stays quiet while enable is clear, and is never raised out of OFF.
- Soft reset zeroes the latch.
- A saturated counter stays saturated.
- The prescaler never ticks on two consecutive cycles at a nonzero rate.
- The rate field is stable without a write.

The exact interval arithmetic, the three-cycle interrupt latency, the edge-polarity selection, the 8191 loaded on arming, and field read-back can only be shown by the scenarios. In those scenarios a scoreboard predicts each interrupt from the input waveform and the programmed rate, and compares it with the design's output.

// File: rtl/ir_cap_pkg.sv
`timescale 1ns/1ps
package ir_cap_pkg;
    localparam int DW = 32;
    localparam int AW = 6;

    localparam logic [AW-1:0] A_RATE = 6'h10;
    localparam logic [AW-1:0] A_STAT = 6'h18;
    localparam logic [AW-1:0] A_CTRL = 6'h1C;
    localparam logic [AW-1:0] A_MODE = 6'h20;

    localparam int NHOLD = 5;
    localparam logic [AW-1:0] HOLD_ADDR [NHOLD] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h14};

    localparam int B_SRST  = 0;
    localparam int B_SEL   = 2;
    localparam int B_LMODE = 7;
    localparam int B_EN    = 15;
    localparam int B_IVL   = 16;
    localparam int B_LVL   = 8;

    typedef enum logic [1:0] {S_OFF, S_ARMED, S_MEASURE} cap_state_e;

    typedef enum logic [1:0] {
        SEL_DECODER = 2'd0,
        SEL_BOTH    = 2'd1,
        SEL_FALL    = 2'd2,
        SEL_RISE    = 2'd3
    } edge_sel_e;
endpackage

// File: rtl/ir_sync_edge.sv
`timescale 1ns/1ps
module ir_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], ir_i};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign lvl_o  = sh_q[STAGES-1];
    assign rise_o = lvl_o & ~prev_q;
    assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/ir_prescaler.sv
`timescale 1ns/1ps
module ir_prescaler #(
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              restart_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    logic [RATE_W-1:0] pc_q;

    assign tick_o = run_i && (pc_q >= rate_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               pc_q <= '0;
        else if (!run_i || restart_i || tick_o)   pc_q <= '0;
        else                                      pc_q <= pc_q + 1'b1;
    end

    // R2: a tick always starts a fresh period of rate+1 cycles
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && rate_i != '0) |=> (!tick_o || rate_i == '0));
endmodule

// File: rtl/ir_interval_fsm.sv
`timescale 1ns/1ps
module ir_interval_fsm
    import ir_cap_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             srst_i,
    input  logic [1:0]       sel_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             tick_i,
    output logic             run_o,
    output logic             restart_o,
    output logic [CNT_W-1:0] lat_o,
    output logic             irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cap_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sat;
    logic             qual, live;

    always_comb begin
        unique case (edge_sel_e'(sel_i))
            SEL_BOTH:    qual = rise_i | fall_i;
            SEL_FALL:    qual = fall_i;
            SEL_RISE:    qual = rise_i;
            default:     qual = 1'b0;
        endcase
    end

    assign live      = en_i && !srst_i;
    assign restart_o = live && qual;
    assign run_o     = (state_q == S_MEASURE);
    assign sum       = {1'b0, cnt_q} + {{CNT_W{1'b0}}, tick_i};
    assign sat       = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:     if (live) state_d = S_ARMED;
            S_ARMED:   if (!live) state_d = S_OFF;
                       else if (qual) state_d = S_MEASURE;
            S_MEASURE: if (!live) state_d = S_OFF;
            default:   state_d = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // datapath and outputs per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lat_o <= '0;
            irq_o <= 1'b0;
        end else if (srst_i) begin
            cnt_q <= '0;
            lat_o <= '0;
            irq_o <= 1'b0;
        end else begin
            unique case (state_q)
                S_OFF: begin
                    cnt_q <= '0;
                    irq_o <= 1'b0;
                end
                S_ARMED: begin
                    if (en_i && qual) begin
                        lat_o <= CNT_MAX;
                        cnt_q <= '0;
                        irq_o <= 1'b1;
                    end else begin
                        irq_o <= 1'b0;
                    end
                end
                S_MEASURE: begin
                    if (en_i && qual) begin
                        lat_o <= sat;
                        cnt_q <= '0;
                        irq_o <= 1'b1;
                    end else begin
                        irq_o <= 1'b0;
                        if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    irq_o <= 1'b0;
                end
            endcase
        end
    end

    // R7: disabled receiver stays silent
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !irq_o);
    // R12: an interrupt is never produced out of OFF
    p_irq_not_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(state_q != S_OFF));
    // R8: soft reset clears the latch
    p_srst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (lat_o == '0 && !irq_o));
    // R3: saturated count does not wrap
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MEASURE && cnt_q == CNT_MAX && live && !qual) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/ir_edge_capture.sv
`timescale 1ns/1ps
module ir_edge_capture
    import ir_cap_pkg::*;
#(
    parameter int RATE_W      = 12,
    parameter int CNT_W       = 13,
    parameter int RATE_RST    = 19,
    parameter int SYNC_STAGES = 2,
    parameter int MODE_W      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ir_in,
    output logic          irq
);
    logic [RATE_W-1:0] rate_q;
    logic              srst_q, en_q;
    logic [1:0]        sel_q, lmode_q;
    logic [MODE_W-1:0] mode_q;
    logic [DW-1:0]     hold_q [NHOLD];

    logic              lvl, rise, fall, tick, run, restart;
    logic [CNT_W-1:0]  lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q  <= RATE_W'(RATE_RST);
            srst_q  <= 1'b0;
            sel_q   <= 2'd0;
            lmode_q <= 2'd0;
            en_q    <= 1'b0;
            mode_q  <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_RATE: rate_q <= bus_wdata[RATE_W-1:0];
                A_CTRL: begin
                    srst_q  <= bus_wdata[B_SRST];
                    sel_q   <= bus_wdata[B_SEL +: 2];
                    lmode_q <= bus_wdata[B_LMODE +: 2];
                    en_q    <= bus_wdata[B_EN];
                end
                A_MODE: mode_q <= bus_wdata[MODE_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NHOLD; g++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   hold_q[g] <= '0;
            else if (bus_we && bus_addr == HOLD_ADDR[g])  hold_q[g] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NHOLD; i++)
            if (bus_addr == HOLD_ADDR[i]) bus_rdata = hold_q[i];
        case (bus_addr)
            A_RATE: bus_rdata[RATE_W-1:0] = rate_q;
            A_STAT: bus_rdata[B_LVL] = lvl;
            A_CTRL: begin
                bus_rdata[B_SRST]          = srst_q;
                bus_rdata[B_SEL +: 2]      = sel_q;
                bus_rdata[B_LMODE +: 2]    = lmode_q;
                bus_rdata[B_EN]            = en_q;
                bus_rdata[B_IVL +: CNT_W]  = lat;
            end
            A_MODE: bus_rdata[MODE_W-1:0] = mode_q;
            default: ;
        endcase
    end

    ir_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ir_i(ir_in),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    ir_prescaler #(.RATE_W(RATE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
        .rate_i(rate_q), .tick_o(tick)
    );

    ir_interval_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_i(en_q), .srst_i(srst_q),
        .sel_i(sel_q), .rise_i(rise), .fall_i(fall), .tick_i(tick),
        .run_o(run), .restart_o(restart), .lat_o(lat), .irq_o(irq)
    );

    // R10: configuration holds without a write
    p_rate_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(rate_q));
endmodule

// File: tb/tb_ir_edge_capture.sv
`timescale 1ns/1ps
module tb_ir_edge_capture;
    import ir_cap_pkg::*;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = A_CTRL;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          ir_in = 1'b0;
    logic          irq;

    always #2 clk = ~clk;

    ir_edge_capture dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ir_in(ir_in), .irq(irq)
    );

    typedef struct {
        int     val;
        longint t;
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    int     checks = 0;
    int     errors = 0;
    int     irq_cnt = 0;
    longint cyc = 0;
    bit     started = 0;

    // reference model state
    int       rate_m = 19;
    bit [1:0] sel_m = 0;
    bit       en_m = 0;
    bit       first_m = 0;
    int       acc_m = 0;
    int       last_exp = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops predicted interrupts
    always @(negedge clk) begin
        if (started && irq) begin
            irq_cnt++;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R5 unexpected irq", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(bus_rdata[28:16] == e.val, e.tag, bus_rdata[28:16], e.val);
                chk(cyc - e.t == 3, "R6 latency", cyc - e.t, 3);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = A_CTRL;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = A_CTRL;
    endtask

    // disable, then enable with a selector: always re-arms
    task automatic arm(input bit [1:0] sel);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h8000 | (32'(sel) << 2));
        sel_m = sel; en_m = 1; first_m = 1; acc_m = 0;
    endtask

    task automatic toggle_after(input int d, input string tag);
        bit q;
        repeat (d) @(negedge clk);
        ir_in = ~ir_in;
        acc_m += d;
        q = (sel_m == 1) || (sel_m == 3 && ir_in) || (sel_m == 2 && !ir_in);
        if (q && en_m) begin
            exp_t e;
            if (first_m) e.val = 8191;
            else e.val = (acc_m / (rate_m + 1)) > 8191 ? 8191 : acc_m / (rate_m + 1);
            e.t = cyc; e.tag = tag;
            sb_q.push_back(e);
            last_exp = e.val;
            first_m = 0; acc_m = 0;
        end
    endtask

    task automatic drain();
        repeat (6) @(negedge clk);
        chk(sb_q.size() == 0, "R5 missing irq", sb_q.size(), 0);
        sb_q.delete();
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        started = 1;

        // R1 reset state
        rd(A_RATE, v); chk(v == 32'd19, "R1 rate reset", v, 19);
        rd(A_CTRL, v); chk(v == 32'd0, "R1 ctrl reset", v, 0);
        rd(A_MODE, v); chk(v == 32'd0, "R1 mode reset", v, 0);
        rd(A_STAT, v); chk(v == 32'd0, "R1 status reset", v, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);

        // R10 / R3 field read-back, R11 plain storage
        wr(A_RATE, 32'hFFFF_F009);
        rd(A_RATE, v); chk(v == 32'h009, "R10 rate field", v, 32'h009);
        wr(A_MODE, 32'hFFFF_FFF2);
        rd(A_MODE, v); chk(v == 32'h2, "R10 mode field", v, 2);
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, v); chk(v == 32'h818C, "R3 R10 ctrl write ignores interval", v, 32'h818C);
        wr(A_CTRL, 32'h0000_0100);
        rd(A_CTRL, v); chk(v == 32'h100, "R10 legacy mode bits", v, 32'h100);
        wr(8'h00, 32'hA5A5_1234);
        wr(8'h14, 32'h0F0F_C3C3);
        rd(6'h00, v); chk(v == 32'hA5A5_1234, "R11 hold word 0x00", v, 32'hA5A5_1234);
        rd(6'h14, v); chk(v == 32'h0F0F_C3C3, "R11 hold word 0x14", v, 32'h0F0F_C3C3);
        rd(6'h24, v); chk(v == 32'h0, "R11 unmapped", v, 0);

        // R2 R4 R5: both edges, rate 9
        rate_m = 9;
        arm(2'd1);
        toggle_after(25, "R4 first edge");
        toggle_after(37, "R2 both edges");
        toggle_after(10, "R2 both edges");
        toggle_after(9,  "R2 both edges");
        toggle_after(100, "R2 both edges");
        toggle_after(3,  "R2 both edges");
        drain();
        rd(A_STAT, v); chk(v == (32'(ir_in) << 8), "R9 level", v, 32'(ir_in) << 8);
        toggle_after(1, "R2 both edges");
        drain();
        rd(A_STAT, v); chk(v == (32'(ir_in) << 8), "R9 level", v, 32'(ir_in) << 8);

        // R5 rising only, rate 4
        wr(A_CTRL, 32'h0);
        wr(A_RATE, 32'd4); rate_m = 4;
        arm(2'd3);
        for (int i = 0; i < 8; i++) toggle_after(11 + 7 * i, "R5 rising only");
        drain();

        // R5 falling only, rate 0
        wr(A_CTRL, 32'h0);
        wr(A_RATE, 32'd0); rate_m = 0;
        arm(2'd2);
        for (int i = 0; i < 8; i++) toggle_after(5 + 4 * i, "R5 falling only");
        drain();

        // R5 decoder setting: no raw interrupts
        arm(2'd0);
        base = irq_cnt;
        for (int i = 0; i < 6; i++) toggle_after(6, "R5 decoder setting");
        drain();
        chk(irq_cnt == base, "R5 no irq when selector 0", irq_cnt - base, 0);

        // R3 saturation, rate 0, both edges
        arm(2'd1);
        toggle_after(5, "R4 first edge");
        toggle_after(9000, "R3 saturate");
        toggle_after(8191, "R3 at max");
        toggle_after(8190, "R3 below max");
        drain();

        // R7 disabled: latch holds, no irq
        wr(A_CTRL, 32'h0000_0004); en_m = 0;
        base = irq_cnt;
        for (int i = 0; i < 5; i++) toggle_after(8, "R7 disabled");
        drain();
        chk(irq_cnt == base, "R7 no irq when disabled", irq_cnt - base, 0);
        rd(A_CTRL, v); chk(v[28:16] == last_exp, "R7 latch holds", v[28:16], last_exp);

        // R8 soft reset clears and silences; R12 re-arm after release
        wr(A_CTRL, 32'h0000_8005); en_m = 0;
        rd(A_CTRL, v); chk(v == 32'h8005, "R8 soft reset clears interval", v, 32'h8005);
        base = irq_cnt;
        for (int i = 0; i < 4; i++) toggle_after(7, "R8 in soft reset");
        drain();
        chk(irq_cnt == base, "R8 no irq in soft reset", irq_cnt - base, 0);
        wr(A_CTRL, 32'h0000_8004);
        sel_m = 1; en_m = 1; first_m = 1; acc_m = 0;
        toggle_after(6, "R12 rearm first edge");
        toggle_after(12, "R12 measure after rearm");
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule